// File: doc/BRIEF.md
# Handshake-Started Compute Kernel Shell

This block wraps a fixed-latency arithmetic kernel so that it is launched by a ready/valid handshake on its ports rather than through a control register. The block raises `readyOut` when it can take an invocation. A caller raises `start` with the argument on `argIn`. The invocation is taken in the cycle where both are high. Each taken invocation computes `x*(x+1)+bias`. Here `x` is the argument captured in that cycle and `bias` is a value held in a register, loaded earlier through a one-word write port.

Results leave in the order they were taken. Each result is shown on `result` while `done` is high, and it is retired in the cycle where `done` meets the downstream `readyIn`.

Two parameters set how invocations overlap:

- With `II = 0` the kernel runs one invocation at a time.
- With `II = N > 0` it is pipelined, and successive accepts are at least N cycles apart.

In pipelined mode, results that have been computed but not yet retired wait in a small in-order buffer. This buffer is sized so that backpressure never drops a result. `HAS_READY_IN = 0` makes the block stall-free: `readyIn` is ignored and every result retires in the cycle it appears.

Top module: `stream_invoke_kernel`

## Requirements
- R1: After reset, `readyOut` is 1 and `done` is 0.
- R2: An invocation is accepted only in a cycle where `start` and `readyOut` are both 1. Its `argIn` value from that cycle is used, and its result is `argIn*(argIn+1)+bias`, computed exactly to `2*ARG_W+1` bits.
- R3: The result of an invocation accepted in cycle c first shows `done` = 1 in cycle c+LAT (LAT = 3 by default, LAT >= 2).
- R4: A write on `cfgWrEn` in cycle w changes `bias` only for invocations accepted in cycle w+1 or later. An invocation accepted in cycle w itself uses the old value.
- R5: While `done` = 1 and `readyIn` = 0 (with `HAS_READY_IN` = 1), `done` stays 1 and `result` holds its value. The result retires in the cycle where `done` and `readyIn` are both 1.
- R6: With `II` = 0, `readyOut` is 0 from the cycle after an accept until the cycle after that invocation retires. A `start` raised while `readyOut` is 0 produces no result.
- R7: With `II` = 1 and `readyIn` high, `start` held for K consecutive cycles is accepted K times. It yields `done` on K consecutive cycles, with the results in acceptance order.
- R8: With `II` = N > 1, two accepts are never closer than N cycles apart. When `start` is held high, accepts occur exactly every N cycles.
- R9: In pipelined mode, at most CAP = ceil(LAT/II)+1 invocations are accepted and not yet retired. While CAP are outstanding, `readyOut` is 0, and no result is lost under backpressure.
- R10: With `HAS_READY_IN` = 0, `readyIn` has no effect. Each result is a single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Invocation request |
| readyOut | output | 1 | Block can accept an invocation this cycle |
| argIn | input | ARG_W | Argument sampled on the accepting cycle |
| cfgWrEn | input | 1 | Write strobe for the held bias argument |
| cfgWrData | input | ARG_W | Bias value to write |
| readyIn | input | 1 | Downstream can take a result (ignored when HAS_READY_IN = 0) |
| done | output | 1 | A result is presented on `result` |
| result | output | 2*ARG_W+1 | Kernel result |

## Verification
Three configurations are driven together: a one-at-a-time kernel, a pipelined kernel with interval 1, and a stall-free kernel with interval 3.

A single isolated start shows the latency and the arithmetic. Holding `start` high while the kernel is busy shows that refused requests leave no trace. A bias write in the same cycle as a start, followed by one later start, separates the old bias value from the new one.

Four back-to-back starts separate full throughput and result order from stalling. Withholding `readyIn` shows the held result and the capacity limit. A start held high on the interval-3 kernel shows the exact accept spacing, and that the stall-free variant ignores `readyIn`.

// File: rtl/sik_pkg.sv
package sik_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accept;  // invocation taken this cycle
    logic pop;     // head result retired this cycle
  } sik_strobe_t;
endpackage

// File: rtl/sik_ctrl.sv
module sik_ctrl #(
  parameter int II    = 0,
  parameter int CAP   = 1,
  parameter int CNT_W = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                done,
  input  logic                popRdy,
  output logic                readyOut,
  output sik_pkg::sik_strobe_t strb
);
  localparam int II_EFF = (II < 1) ? 1 : II;
  localparam int GAP_W  = $clog2(II_EFF) + 1;

  logic [CNT_W-1:0] inflight;
  logic [GAP_W-1:0] gapCnt;
  logic             gapOpen;

  assign readyOut   = (inflight < CNT_W'(CAP)) && gapOpen;
  assign strb.accept = start && readyOut;
  assign strb.pop    = done && popRdy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inflight <= '0;
    else       inflight <= inflight + CNT_W'(strb.accept) - CNT_W'(strb.pop);
  end

  generate
    if (II > 1) begin : g_gap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            gapCnt <= '0;
        else if (strb.accept) gapCnt <= GAP_W'(II - 1);
        else if (gapCnt != 0) gapCnt <= gapCnt - GAP_W'(1);
      end
      assign gapOpen = (gapCnt == '0);
    end else begin : g_nogap
      assign gapCnt  = '0;
      assign gapOpen = 1'b1;
    end
  endgenerate

  // R6 R8
  generate
    if (II != 1) begin : g_spacing_chk
      ii_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.accept |=> !readyOut);
    end
  endgenerate

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> inflight != '0);

  // R9
  cap_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    inflight <= CNT_W'(CAP));
endmodule

// File: rtl/sik_datapath.sv
module sik_datapath #(
  parameter int ARG_W = 8,
  parameter int RES_W = 17,
  parameter int LAT   = 3,
  parameter int CAP   = 1,
  parameter int PTR_W = 1,
  parameter int CNT_W = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sik_pkg::sik_strobe_t strb,
  input  logic [ARG_W-1:0]     argIn,
  input  logic                 cfgWrEn,
  input  logic [ARG_W-1:0]     cfgWrData,
  output logic                 done,
  output logic [RES_W-1:0]     result
);
  localparam int STG = LAT - 1;

  logic [ARG_W-1:0] biasReg;
  logic [RES_W-1:0] prod;
  logic [STG-1:0]   stgVal;
  logic [RES_W-1:0] stgRes [STG];
  logic [RES_W-1:0] fifoMem [CAP];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fifoCnt;
  logic             push;

  function automatic logic [PTR_W-1:0] nxtPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(CAP - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        biasReg <= '0;
    else if (cfgWrEn) biasReg <= cfgWrData;
  end

  assign prod = RES_W'(argIn) * (RES_W'(argIn) + RES_W'(1)) + RES_W'(biasReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stgVal <= '0;
    else begin
      stgVal[0] <= strb.accept;
      for (int i = 1; i < STG; i++) stgVal[i] <= stgVal[i-1];
    end
  end

  always_ff @(posedge clk) begin
    stgRes[0] <= prod;
    for (int i = 1; i < STG; i++) stgRes[i] <= stgRes[i-1];
  end

  assign push = stgVal[STG-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (push)     wrPtr <= nxtPtr(wrPtr);
      if (strb.pop) rdPtr <= nxtPtr(rdPtr);
      fifoCnt <= fifoCnt + CNT_W'(push) - CNT_W'(strb.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifoMem[wrPtr] <= stgRes[STG-1];
  end

  assign done   = (fifoCnt != '0);
  assign result = fifoMem[rdPtr];

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !strb.pop |=> done && $stable(result));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    push && !strb.pop |-> fifoCnt < CNT_W'(CAP));
endmodule

// File: rtl/stream_invoke_kernel.sv
module stream_invoke_kernel #(
  parameter int ARG_W        = 8,
  parameter int LAT          = 3,
  parameter int II           = 0,
  parameter int HAS_READY_IN = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic                 readyOut,
  input  logic [ARG_W-1:0]     argIn,
  input  logic                 cfgWrEn,
  input  logic [ARG_W-1:0]     cfgWrData,
  input  logic                 readyIn,
  output logic                 done,
  output logic [2*ARG_W:0]     result
);
  localparam int RES_W  = 2 * ARG_W + 1;
  localparam int II_EFF = (II < 1) ? 1 : II;
  localparam int CAP    = (II == 0) ? 1 : ((LAT + II_EFF - 1) / II_EFF + 1);
  localparam int PTR_W  = (CAP > 1) ? $clog2(CAP) : 1;
  localparam int CNT_W  = $clog2(CAP + 1);

  sik_pkg::sik_strobe_t strb;
  logic popRdy;

  generate
    if (HAS_READY_IN != 0) begin : g_bp
      assign popRdy = readyIn;
    end else begin : g_stallfree
      assign popRdy = 1'b1;
    end
  endgenerate

  sik_ctrl #(.II(II), .CAP(CAP), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .popRdy(popRdy),
    .readyOut(readyOut), .strb(strb)
  );

  sik_datapath #(.ARG_W(ARG_W), .RES_W(RES_W), .LAT(LAT), .CAP(CAP),
                 .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .argIn(argIn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .done(done), .result(result)
  );
endmodule

// File: tb/stream_invoke_kernel_bench.sv
module stream_invoke_kernel_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] argIn = '0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic readyIn = 1'b1;
  logic rdyA, rdyB, rdyC, doneA, doneB, doneC;
  logic [16:0] resA, resB, resC;
  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  stream_invoke_kernel u_stream_invoke_kernel (
    .clk(clk), .rstN(rstN), .start(start), .readyOut(rdyA), .argIn(argIn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .readyIn(readyIn),
    .done(doneA), .result(resA));

  stream_invoke_kernel #(.II(1)) u_pipe (
    .clk(clk), .rstN(rstN), .start(start), .readyOut(rdyB), .argIn(argIn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .readyIn(readyIn),
    .done(doneB), .result(resB));

  stream_invoke_kernel #(.II(3), .HAS_READY_IN(0)) u_gap (
    .clk(clk), .rstN(rstN), .start(start), .readyOut(rdyC), .argIn(argIn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .readyIn(readyIn),
    .done(doneC), .result(resC));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] kres(input int x, input int b);
    return 32'(x * (x + 1) + b);
  endfunction

  task automatic drain();
    start = 1'b0; readyIn = 1'b1; cfgWrEn = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic setBias(input int b);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = 8'(b);
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 readyOut A", 32'(rdyA), 1);
    chk("R1 readyOut B", 32'(rdyB), 1);
    chk("R1 readyOut C", 32'(rdyC), 1);
    chk("R1 done A", 32'(doneA), 0);
    chk("R1 done C", 32'(doneC), 0);
  endtask

  // one-at-a-time kernel: latency, arithmetic, refused starts
  task automatic testSingle();
    setBias(5);
    for (int k = 0; k < 9; k++) begin
      if (k == 0) chk("R6 idle ready", 32'(rdyA), 1);
      if (k == 1 || k == 2) begin
        chk("R6 busy ready", 32'(rdyA), 0);
        chk("R3 early done", 32'(doneA), 0);
      end
      if (k == 3) begin
        chk("R3 done at LAT", 32'(doneA), 1);
        chk("R2 result", resA, kres(7, 5));
      end
      if (k == 4) chk("R6 ready after retire", 32'(rdyA), 1);
      if (k >= 4) chk("R6 refused start gives no done", 32'(doneA), 0);
      start = (k < 3);
      argIn = (k == 0) ? 8'd7 : 8'd9;
      @(negedge clk);
    end
    drain();
  endtask

  // bias written in the start cycle vs one cycle earlier
  task automatic testBias();
    for (int k = 0; k < 9; k++) begin
      if (k == 3) chk("R4 same-cycle write uses old bias", resA, kres(2, 5));
      if (k == 4) chk("R4 ready", 32'(rdyA), 1);
      if (k == 7) chk("R4 new bias", resA, kres(3, 100));
      cfgWrEn = (k == 0); cfgWrData = 8'd100;
      start = (k == 0 || k == 4);
      argIn = (k == 0) ? 8'd2 : 8'd3;
      @(negedge clk);
    end
    drain();
  endtask

  // downstream backpressure holds the result
  task automatic testHold();
    for (int k = 0; k < 8; k++) begin
      if (k >= 3 && k <= 6) begin
        chk("R5 done held", 32'(doneA), 1);
        chk("R5 result held", resA, kres(4, 100));
        chk("R5 no accept while held", 32'(rdyA), 0);
      end
      if (k == 7) begin
        chk("R5 retired", 32'(doneA), 0);
        chk("R5 ready again", 32'(rdyA), 1);
      end
      start = (k == 0); argIn = 8'd4;
      readyIn = (k >= 6);
      @(negedge clk);
    end
    drain();
  endtask

  // interval 1: back-to-back accepts and in-order results
  task automatic testPipe();
    for (int k = 0; k < 8; k++) begin
      if (k < 4) chk("R7 ready every cycle", 32'(rdyB), 1);
      if (k >= 3 && k <= 6) begin
        chk("R7 done consecutive", 32'(doneB), 1);
        chk("R7 result order", resB, kres(k - 2, 100));
      end
      if (k == 7) chk("R7 done ends", 32'(doneB), 0);
      start = (k < 4); argIn = 8'(k + 1);
      readyIn = 1'b1;
      @(negedge clk);
    end
    drain();
  endtask

  // interval 1 under backpressure: capacity limit, nothing lost
  task automatic testCapacity();
    for (int k = 0; k < 11; k++) begin
      if (k == 4 || k == 5) chk("R9 full blocks start", 32'(rdyB), 0);
      if (k >= 6 && k <= 9) begin
        chk("R9 done after release", 32'(doneB), 1);
        chk("R9 result kept in order", resB, kres(k + 4, 100));
      end
      if (k == 10) chk("R9 only accepted ones return", 32'(doneB), 0);
      start = (k < 6); argIn = 8'(10 + k);
      readyIn = (k >= 6);
      @(negedge clk);
    end
    drain();
  endtask

  // interval 3, stall-free: spacing and ignored readyIn
  task automatic testGap();
    for (int k = 0; k < 11; k++) begin
      if (k < 7) chk("R8 accept spacing", 32'(rdyC), (k % 3 == 0) ? 1 : 0);
      if (k == 3) chk("R10 pulse 1", resC, kres(20, 100));
      if (k == 6) chk("R10 pulse 2", resC, kres(23, 100));
      if (k == 9) chk("R10 pulse 3", resC, kres(26, 100));
      if (k >= 3) chk("R10 done is one-cycle pulse", 32'(doneC), (k % 3 == 0) ? 1 : 0);
      start = (k < 7); argIn = 8'(20 + k);
      readyIn = 1'b0;
      @(negedge clk);
    end
    drain();
  endtask

  initial begin
    #(20 * 100000);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testBias();
    testHold();
    testPipe();
    testCapacity();
    testGap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule